// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned N-bit operands and a one-bit carry-in. It returns an N-bit sum and a carry-out. The operands are cut into 4-bit slices. Each slice forms the carry into each of its bit positions from per-bit generate (`a & b`) and propagate (`a ^ b`) terms. Every carry is a flat sum-of-products written out on its own, so no carry ripples from bit to bit inside a slice. The same propagate term also forms the sum bit. The carry-out of each slice is the carry-in of the next slice up, so the slices form a linear chain.

The width is a parameter and must be a multiple of 4. A second parameter places a register after the adder so that the same arithmetic can be timed between flops. That register clears on a synchronous active-low reset. With the register removed, the block is purely combinational, and its clock and reset have no effect.

Top module: `grouped_cla_adder`

## Requirements
- R1: With the output register present, `{cout, sum}` equals the (N+1)-bit value `a + b + cin` of the inputs sampled at the previous rising clock edge. This holds at N = 4, 12 and 32.
- R2: The carry entering 4-bit slice k (bits 4k and up) equals bit 4k of `a[4k-1:0] + b[4k-1:0] + cin`. A slice's carry-out is g3 | g2·p3 | g1·p2·p3 | g0·p1·p2·p3 | cin·p0·p1·p2·p3, where g = a AND b and p = a XOR b for that bit.
- R3: The carry into each bit i comes from that bit's own product terms inside its slice and equals bit i of `a[i-1:0] + b[i-1:0] + cin`. Sum bit i equals `a[i] ^ b[i] ^` that carry.
- R4: At N = 4, `a = 4'b0011`, `b = 4'b0101`, `cin = 0` gives `sum = 4'b1000` and `cout = 0`.
- R5: With the output register present, a rising edge with `rst_n` low sets `sum` to all zeros and `cout` to 0, whatever the inputs.
- R6: A carry-in travels through every slice. All-ones plus zero with `cin = 1` gives a zero sum and `cout = 1`. All-ones plus all-ones with `cin = 1` gives an all-ones sum and `cout = 1`.
- R7: With the output register left out, `{cout, sum}` equals `a + b + cin` for the present inputs, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
In the registered variant, a result is due on the first rising edge after its operands settle. The bench changes the operands on a falling edge and reads the outputs 2 ns after the next rising edge, well before the following falling edge. The reset clear appears at that same edge, so it is read at the same point. In the combinational variant, the result is due as soon as the inputs change, and the bench reads it 1 ns after driving with no edge in between. The checker compares each slice carry and each bit carry with a low-part arithmetic sum at every edge. It checks the registered result against an expectation it registered itself one cycle earlier.

// File: rtl/cla_pkg.sv
// Shared definitions for the grouped carry-lookahead adder.
// Assumes the lookahead slice width stays at 4 bits.
package cla_pkg;

    localparam int unsigned GRP_W = 4;

    // Generate and propagate terms of one lookahead slice.
    typedef struct packed {
        logic [GRP_W-1:0] gen;
        logic [GRP_W-1:0] prop;
    } grp_gp_t;

endpackage

// File: rtl/cla_gp_gen.sv
// Per-bit generate and propagate terms.
// Propagate uses XOR so it also serves as the half-sum.
module cla_gp_gen #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);

    // One AND/XOR pair per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gen[i]  = a[i] & b[i];
        assign prop[i] = a[i] ^ b[i];
    end

endmodule

// File: rtl/cla_group4.sv
// One 4-bit lookahead slice: the carry into each bit and the slice
// carry-out, each a separate flat sum-of-products with no shared terms.
// Assumes gp holds the XOR propagate and AND generate of the slice.
module cla_group4
    import cla_pkg::*;
(
    input  grp_gp_t          gp,
    input  logic             cin,
    output logic [GRP_W-1:0] carry,
    output logic             cout
);

    logic [GRP_W-1:0] g;
    logic [GRP_W-1:0] p;

    assign g = gp.gen;
    assign p = gp.prop;

    // Flat carry expressions, one per position.
    always_comb begin
        carry[0] = cin;
        carry[1] = g[0]
                 | (cin  & p[0]);
        carry[2] = g[1]
                 | (g[0] & p[1])
                 | (cin  & p[0] & p[1]);
        carry[3] = g[2]
                 | (g[1] & p[2])
                 | (g[0] & p[1] & p[2])
                 | (cin  & p[0] & p[1] & p[2]);
        cout     = g[3]
                 | (g[2] & p[3])
                 | (g[1] & p[2] & p[3])
                 | (g[0] & p[1] & p[2] & p[3])
                 | (cin  & p[0] & p[1] & p[2] & p[3]);
    end

endmodule

// File: rtl/cla_sum_xor.sv
// Final sum: the half-sum XORed with the carry into each bit.
module cla_sum_xor #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] carry,
    output logic [WIDTH-1:0] sum
);

    // Bitwise XOR of the half-sum and the incoming carry.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i] = prop[i] ^ carry[i];
    end

endmodule

// File: rtl/grouped_cla_adder.sv
// Top of the grouped carry-lookahead adder. WIDTH/4 lookahead slices
// are chained through their slice carries. An optional register with a
// synchronous active-low reset sits on the result.
// Assumes WIDTH is a non-zero multiple of 4.
module grouped_cla_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int unsigned NGRP = WIDTH / GRP_W;

    logic [WIDTH-1:0] gen_w;
    logic [WIDTH-1:0] prop_w;
    logic [WIDTH-1:0] bit_c;
    logic [NGRP:0]    grp_c;
    logic [WIDTH-1:0] sum_c;

    cla_gp_gen #(.WIDTH(WIDTH)) u_gp (
        .a    (a),
        .b    (b),
        .gen  (gen_w),
        .prop (prop_w)
    );

    assign grp_c[0] = cin;

    // Linear chain of lookahead slices.
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        grp_gp_t gp_k;
        assign gp_k.gen  = gen_w[k*GRP_W +: GRP_W];
        assign gp_k.prop = prop_w[k*GRP_W +: GRP_W];

        cla_group4 u_slice (
            .gp    (gp_k),
            .cin   (grp_c[k]),
            .carry (bit_c[k*GRP_W +: GRP_W]),
            .cout  (grp_c[k+1])
        );
    end

    cla_sum_xor #(.WIDTH(WIDTH)) u_sum (
        .prop  (prop_w),
        .carry (bit_c),
        .sum   (sum_c)
    );

    if (REG_OUT) begin : g_reg
        // Capture the result; clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum  <= '0;
                cout <= 1'b0;
            end else begin
                sum  <= sum_c;
                cout <= grp_c[NGRP];
            end
        end
    end else begin : g_comb
        assign sum  = sum_c;
        assign cout = grp_c[NGRP];
    end

endmodule

// File: rtl/grouped_cla_adder_chk.sv
// Checker for grouped_cla_adder. It compares internal carries and outputs
// with arithmetic sums of the operands. It is attached to every instance
// by the bind at the end of this file.
module grouped_cla_adder_chk #(
    parameter int unsigned WIDTH   = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [WIDTH/4:0] grp_c,
    input logic [WIDTH-1:0] bit_c
);

    localparam int unsigned NG = WIDTH / 4;

    // Slice carries against the carry of the lower-part sum.
    for (genvar k = 1; k <= NG; k++) begin : g_grp
        localparam int unsigned LW = 4 * k;
        logic [LW:0] lo_sum;
        assign lo_sum = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]} + {{LW{1'b0}}, cin};
        p_grp_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
            grp_c[k] == lo_sum[LW]);
    end

    // Bit carries against the carry of the lower-part sum.
    for (genvar i = 1; i < WIDTH; i++) begin : g_bit
        logic [i:0] lo_sum;
        assign lo_sum = {1'b0, a[i-1:0]} + {1'b0, b[i-1:0]} + {{i{1'b0}}, cin};
        p_bit_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
            bit_c[i] == lo_sum[i]);
    end

    if (REG_OUT) begin : g_reg
        logic [WIDTH:0] exp_q;
        logic           run_q;
        logic           started;
        logic           rst_q;

        // Expected result one cycle behind, and whether the last edge ran.
        always_ff @(posedge clk) begin
            exp_q   <= {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
            run_q   <= rst_n;
            started <= 1'b1;
            rst_q   <= rst_n;
        end

        p_reg_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
            run_q |-> ({cout, sum} == exp_q));

        // After an edge taken in reset, the outputs read zero.
        always @(negedge clk) begin
            if (started === 1'b1 && rst_q === 1'b0) begin
                p_reset_clear_r5: assert (sum == '0 && cout == 1'b0);
            end
        end
    end else begin : g_comb
        p_comb_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
            {cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
    end

endmodule

bind grouped_cla_adder grouped_cla_adder_chk #(
    .WIDTH   (WIDTH),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .grp_c (grp_c),
    .bit_c (bit_c)
);

// File: tb/grouped_cla_adder_test.sv
`timescale 1ns/1ps
// Bench: registered adders at 32 and 12 bits, combinational adder at 4 bits.
module grouped_cla_adder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a32, b32, s32;
    logic [11:0] a12, b12, s12;
    logic [3:0]  a4, b4, s4;
    logic        ci32, ci12, ci4, co32, co12, co4;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    grouped_cla_adder #(.WIDTH(32), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .a(a32), .b(b32), .cin(ci32), .sum(s32), .cout(co32));
    grouped_cla_adder #(.WIDTH(12), .REG_OUT(1'b1)) uut12 (
        .clk(clk), .rst_n(rst_n), .a(a12), .b(b12), .cin(ci12), .sum(s12), .cout(co12));
    grouped_cla_adder #(.WIDTH(4), .REG_OUT(1'b0)) uut4 (
        .clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .cin(ci4), .sum(s4), .cout(co4));

    function automatic logic [63:0] ref_add(logic [31:0] x, logic [31:0] y, logic c, int w);
        logic [63:0] m = (64'd1 << w) - 64'd1;
        return ({32'd0, x} & m) + ({32'd0, y} & m) + {63'd0, c};
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Drive all three adders on a falling edge, then check each at its due time.
    task automatic apply(string req, logic [31:0] x, logic [31:0] y, logic c);
        @(negedge clk);
        a32 = x;        b32 = y;        ci32 = c;
        a12 = x[11:0];  b12 = y[11:0];  ci12 = c;
        a4  = x[3:0];   b4  = y[3:0];   ci4  = c;
        #1;
        chk({req, " R7 n4"}, {59'd0, co4, s4}, ref_add(x, y, c, 4));
        @(posedge clk);
        #2;
        chk({req, " R1 n32"}, {31'd0, co32, s32}, ref_add(x, y, c, 32));
        chk({req, " R1 n12"}, {51'd0, co12, s12}, ref_add(x, y, c, 12));
    endtask

    initial begin
        a32 = '1; b32 = '1; ci32 = 1'b1;
        a12 = '1; b12 = '1; ci12 = 1'b1;
        a4 = '0;  b4 = '0;  ci4 = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk("R5 reset n32", {31'd0, co32, s32}, 64'd0);
        chk("R5 reset n12", {51'd0, co12, s12}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        apply("R4 worked", 32'h3, 32'h5, 1'b0);
        chk("R4 worked sum", {59'd0, co4, s4}, 64'h08);
        apply("R6 ones+0+1", 32'hFFFF_FFFF, 32'h0, 1'b1);
        apply("R6 ones+ones+1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        apply("zeros", 32'h0, 32'h0, 1'b0);
        apply("alt", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        apply("alt2", 32'h5555_5555, 32'h5555_5555, 1'b0);
        apply("R2 slice cross", 32'h0000_000F, 32'h1, 1'b0);
        apply("R2 slice cross2", 32'h00FF_F0FF, 32'h0000_0F01, 1'b0);
        apply("R3 mid slice", 32'h0000_0007, 32'h0, 1'b1);

        // Reset taken mid-run clears the registered outputs.
        @(negedge clk);
        a32 = 32'h1234_5678; b32 = 32'h1111_1111; a12 = 12'h678; b12 = 12'h111;
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk("R5 mid reset n32", {31'd0, co32, s32}, 64'd0);
        chk("R5 mid reset n12", {51'd0, co12, s12}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Seeded random operands for R1, R2 and R3.
        void'($urandom(32'd20081));
        for (int n = 0; n < 400; n++) begin
            apply("R1 random", $urandom, $urandom, 1'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule